// File: doc/BRIEF.md
# Serial Receive Deframer with Error Checking

The block takes an NRZ serial stream and its shift clock, both synchronous to the system clock. It counts the bits of each transfer. A transfer ends when the shift clock has been quiet for a set number of system clocks. A short transfer is decoded as a control frame. A long one is decoded as a 32-bit word carrying a leading sync bit, a word-type bit and an optional parity bit. Each result goes into its own output latch, and a separate active-low pulse marks each control frame and each word received.

The block checks every transfer for bit-count, parity and sync faults and for words that the host did not read in time. The faults are reported as a sticky 2-bit code and a sticky overflow flag. In burst mode one continuous stream carries a single header, followed by back-to-back words. The block slices the words out at fixed bit intervals until the line goes quiet. The host read strobe is modelled as a plain input.

Top module: `serial_rx_deframer`

## Requirements
- R1: A transfer of at most 4 bits is a control frame. The bits arrive in the order sync, data flag, command flag, fourth bit, and the fourth bit is present only when `short_ctl_i` is 0. Its fields appear on `ctl_sync_o`, `ctl_data_o`, `ctl_cmd_o` and `ctl_bit4_o` (0 in short mode), and `ctl_rcv_no` pulses.
- R2: A non-burst word is sent as sync, word-type bit, 32 data bits MSB first, then one parity bit when `par_en_i` is 1. The block presents these on `word_sync_o`, `word_wi_o`, `word_o` and `word_par_o` (0 without parity), and `word_rcv_no` pulses.
- R3: A transfer ends once 4 system clocks pass with no rising edge of `rx_clk_i`. Rising edges 4 clocks apart belong to the same transfer.
- R4: Each receive pulse is low for exactly 2 clocks. It starts one clock after the latched fields, `err_o` and `ovf_o` have taken their new values.
- R5: The error codes are 00 for no fault, 10 for a bit-count fault, 01 for a parity fault and 11 for a sync fault. A frame expects 3 bits in short mode and 4 in long mode. A word expects 34 bits, or 35 with parity. Any other length gives code 10, and a word of the wrong length still pulses.
- R6: With parity enabled and the length correct, the 32 data bits plus the parity bit must hold an odd number of ones when `par_odd_i` is 1, and an even number when it is 0. Otherwise code 01 is raised.
- R7: A first bit of 0 is a sync fault. The ranking is sync above parity above bit count. `err_o` is sticky and only ever moves to a higher-ranked code.
- R8: If a word is latched before the rising edge of `rd_hi_ni` that completes the read of the previous word, `ovf_o` is set and the latch takes the new word.
- R9: `err_clr_ni` held low at a clock edge clears `err_o` to 00 and `ovf_o` to 0.
- R10: `rst_ni` low clears the sequencing, the flags and the pulses. The word latch keeps its value.
- R11: In burst mode (`burst_i` = 1) the first two bits are sync and word type. After them, a word is latched and pulsed every 32 bits, or every 33 with parity, and each word is parity-checked on its own.
- R12: In burst mode every word reports the sync and word-type bits from the header. Bits left over past the last complete word when the gap arrives raise code 10 without a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| err_clr_ni | input | 1 | Active-low clear of error code and overflow flag |
| short_ctl_i | input | 1 | 1: 3-bit control frames, 0: 4-bit control frames |
| par_en_i | input | 1 | Words carry a trailing parity bit |
| par_odd_i | input | 1 | 1: odd parity, 0: even parity |
| burst_i | input | 1 | Burst reception mode |
| rx_clk_i | input | 1 | Serial shift clock, data taken on its rising edge |
| rx_data_i | input | 1 | Serial NRZ data |
| rd_hi_ni | input | 1 | Upper-half read strobe, read complete on its rising edge |
| word_o | output | DATA_W | Received word latch |
| word_sync_o | output | 1 | Sync bit of the latched word |
| word_wi_o | output | 1 | Word-type bit of the latched word |
| word_par_o | output | 1 | Parity bit of the latched word |
| ctl_sync_o | output | 1 | Sync bit of the latched control frame |
| ctl_data_o | output | 1 | Data flag of the control frame |
| ctl_cmd_o | output | 1 | Command flag of the control frame |
| ctl_bit4_o | output | 1 | Fourth bit of a long control frame |
| word_rcv_no | output | 1 | Active-low word-received pulse |
| ctl_rcv_no | output | 1 | Active-low frame-received pulse |
| err_o | output | 2 | Sticky error code |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
The assertions assume that the serial inputs, the mode pins and the strobes are synchronous to the system clock. They assume the mode pins stay constant during a transfer and that rising edges of the shift clock are at least two clocks apart. They also assume the error clear is never pulsed in the two clocks before a receive pulse. The bench drives every input on the falling system edge and changes modes only between transfers. It spaces shift-clock edges four clocks apart and leaves long idle gaps. It pulses the error clear only once the line has settled, so every receive pulse follows a stable error code.

// File: rtl/srx_pkg.sv
package srx_pkg;
  typedef enum logic [1:0] {
    ERR_NONE = 2'b00,
    ERR_PAR  = 2'b01,
    ERR_CNT  = 2'b10,
    ERR_SYNC = 2'b11
  } err_code_e;

  // sync > parity > bit count > none
  function automatic logic [1:0] err_rank(err_code_e e);
    case (e)
      ERR_SYNC: err_rank = 2'd3;
      ERR_PAR:  err_rank = 2'd2;
      ERR_CNT:  err_rank = 2'd1;
      default:  err_rank = 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/srx_edge.sv
module srx_edge #(
  parameter int GAP_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_clk_i,
  output logic bit_stb_o,
  output logic end_stb_o
);
  localparam int GW = (GAP_CYC > 2) ? $clog2(GAP_CYC) : 1;
  localparam logic [GW-1:0] GAP_LAST = GW'(GAP_CYC - 1);

  logic          clk_q;
  logic          active_q;
  logic [GW-1:0] gap_q;

  assign bit_stb_o = rx_clk_i & ~clk_q;
  assign end_stb_o = active_q & ~bit_stb_o & (gap_q == GAP_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_q    <= 1'b0;
      active_q <= 1'b0;
      gap_q    <= '0;
    end else begin
      clk_q <= rx_clk_i;
      if (bit_stb_o) begin
        active_q <= 1'b1;
        gap_q    <= '0;
      end else if (active_q) begin
        if (gap_q == GAP_LAST) begin
          active_q <= 1'b0;
          gap_q    <= '0;
        end else begin
          gap_q <= gap_q + 1'b1;
        end
      end
    end
  end

  // R3
  gap_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_stb_o |-> !bit_stb_o && $past(!bit_stb_o));
endmodule

// File: rtl/srx_frame.sv
module srx_frame
  import srx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_stb_i,
  input  logic              bit_val_i,
  input  logic              end_stb_i,
  input  logic              short_ctl_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              burst_i,
  output logic              ctl_evt_o,
  output logic              word_evt_o,
  output logic              err_evt_o,
  output err_code_e         evt_err_o,
  output logic [DATA_W-1:0] w_data_o,
  output logic              w_sync_o,
  output logic              w_wi_o,
  output logic              w_par_o,
  output logic              c_sync_o,
  output logic              c_data_o,
  output logic              c_cmd_o,
  output logic              c_bit4_o
);
  localparam int SR_W  = DATA_W + 3;
  localparam int IW    = $clog2(SR_W);
  localparam int CNT_W = $clog2(SR_W + 1) + 1;
  localparam int WC_W  = $clog2(DATA_W + 2);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] LEN_NP  = CNT_W'(DATA_W + 2);
  localparam logic [CNT_W-1:0] LEN_P   = CNT_W'(DATA_W + 3);
  localparam logic [CNT_W-1:0] CTL_MAX = CNT_W'(4);

  logic [SR_W-1:0]  sr_q, nxt_sr, src;
  logic [CNT_W-1:0] tot_q, word_len, ctl_len;
  logic [WC_W-1:0]  wcnt_q, wlen_m1;
  logic             seen_q, hdr_sync_q, hdr_wi_q;
  logic             hdr_done, burst_word, ctl_end, word_end, tail_end;
  logic [IW-1:0]    s_idx;
  logic             par_bad, cnt_bad, sync_bit, wi_bit;
  err_code_e        word_err, ctl_err;

  assign nxt_sr   = {sr_q[SR_W-2:0], bit_val_i};
  assign hdr_done = tot_q >= CNT_W'(2);
  assign wlen_m1  = par_en_i ? WC_W'(DATA_W) : WC_W'(DATA_W - 1);
  assign word_len = par_en_i ? LEN_P : LEN_NP;
  assign ctl_len  = short_ctl_i ? CNT_W'(3) : CNT_W'(4);

  assign burst_word = burst_i & bit_stb_i & hdr_done & (wcnt_q == wlen_m1);
  assign ctl_end    = end_stb_i & (~burst_i | ~seen_q) & (tot_q <= CTL_MAX);
  assign word_end   = end_stb_i & (~burst_i | ~seen_q) & (tot_q > CTL_MAX);
  assign tail_end   = end_stb_i & burst_i & seen_q & (wcnt_q != '0);

  // first bit of the finished transfer, clamped to the register depth
  assign s_idx = (tot_q > CNT_W'(SR_W)) ? IW'(SR_W - 1) : IW'(tot_q - 1'b1);

  assign src      = burst_word ? nxt_sr : sr_q;
  assign w_data_o = par_en_i ? src[DATA_W:1] : src[DATA_W-1:0];
  assign w_par_o  = par_en_i & src[0];
  assign sync_bit = burst_word ? hdr_sync_q : sr_q[s_idx];
  assign wi_bit   = burst_word ? hdr_wi_q : sr_q[IW'(s_idx - 1'b1)];
  assign w_sync_o = sync_bit;
  assign w_wi_o   = wi_bit;

  assign cnt_bad = word_end & (tot_q != word_len);
  assign par_bad = par_en_i & ((^{w_data_o, src[0]}) != par_odd_i);

  always_comb begin
    if (!sync_bit)              word_err = ERR_SYNC;
    else if (par_bad && !cnt_bad) word_err = ERR_PAR;
    else if (cnt_bad)           word_err = ERR_CNT;
    else                        word_err = ERR_NONE;
  end

  assign c_sync_o = sr_q[s_idx];
  assign c_data_o = short_ctl_i ? sr_q[1] : sr_q[2];
  assign c_cmd_o  = short_ctl_i ? sr_q[0] : sr_q[1];
  assign c_bit4_o = ~short_ctl_i & sr_q[0];

  always_comb begin
    if (!c_sync_o)             ctl_err = ERR_SYNC;
    else if (tot_q != ctl_len) ctl_err = ERR_CNT;
    else                       ctl_err = ERR_NONE;
  end

  always_comb begin
    if (ctl_end)                      evt_err_o = ctl_err;
    else if (word_end || burst_word)  evt_err_o = word_err;
    else if (tail_end)                evt_err_o = ERR_CNT;
    else                              evt_err_o = ERR_NONE;
  end

  assign ctl_evt_o  = ctl_end;
  assign word_evt_o = word_end | burst_word;
  assign err_evt_o  = ctl_end | word_end | burst_word | tail_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q       <= '0;
      tot_q      <= '0;
      wcnt_q     <= '0;
      seen_q     <= 1'b0;
      hdr_sync_q <= 1'b0;
      hdr_wi_q   <= 1'b0;
    end else if (end_stb_i) begin
      tot_q  <= '0;
      wcnt_q <= '0;
      seen_q <= 1'b0;
    end else if (bit_stb_i) begin
      sr_q <= nxt_sr;
      if (tot_q != CNT_MAX) tot_q <= tot_q + 1'b1;
      if (tot_q == CNT_W'(0)) hdr_sync_q <= bit_val_i;
      if (tot_q == CNT_W'(1)) hdr_wi_q   <= bit_val_i;
      if (burst_i && hdr_done) begin
        if (wcnt_q == wlen_m1) begin
          wcnt_q <= '0;
          seen_q <= 1'b1;
        end else begin
          wcnt_q <= wcnt_q + 1'b1;
        end
      end
    end
  end

  // R11
  burst_slice_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_evt_o && burst_i && !end_stb_i) |=> seen_q && wcnt_q == '0);
endmodule

// File: rtl/srx_flags.sv
module srx_flags
  import srx_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      err_clr_ni,
  input  logic      rd_hi_ni,
  input  logic      err_evt_i,
  input  err_code_e evt_err_i,
  input  logic      word_evt_i,
  input  logic      ctl_evt_i,
  output logic [1:0] err_o,
  output logic      ovf_o,
  output logic      word_rcv_no,
  output logic      ctl_rcv_no
);
  err_code_e  err_q;
  logic       rd_q, rd_done, unread_q, ovf_q;
  logic [1:0] evt, rcv_n;

  assign rd_done = rd_hi_ni & ~rd_q;
  assign err_o   = err_q;
  assign ovf_o   = ovf_q;
  assign evt     = {word_evt_i, ctl_evt_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q     <= 1'b1;
      unread_q <= 1'b0;
      ovf_q    <= 1'b0;
      err_q    <= ERR_NONE;
    end else begin
      rd_q <= rd_hi_ni;
      if (word_evt_i)   unread_q <= 1'b1;
      else if (rd_done) unread_q <= 1'b0;
      if (!err_clr_ni) begin
        ovf_q <= 1'b0;
        err_q <= ERR_NONE;
      end else begin
        if (word_evt_i && unread_q && !rd_done) ovf_q <= 1'b1;
        if (err_evt_i && err_rank(evt_err_i) > err_rank(err_q)) err_q <= evt_err_i;
      end
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_ch
    logic       stage_q;
    logic [1:0] pcnt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q <= 1'b0;
        pcnt_q  <= '0;
      end else begin
        stage_q <= evt[g];
        if (stage_q)              pcnt_q <= 2'd2;
        else if (pcnt_q != 2'd0)  pcnt_q <= pcnt_q - 1'b1;
      end
    end
    assign rcv_n[g] = (pcnt_q == 2'd0);

    // R4
    pulse_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(rcv_n[g]) |=> !rcv_n[g] ##1 rcv_n[g]);
    // R4
    err_settled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(rcv_n[g]) |-> $stable(err_q) && $stable(ovf_q));
  end

  assign ctl_rcv_no  = rcv_n[0];
  assign word_rcv_no = rcv_n[1];

  // R7
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q != ERR_NONE && err_clr_ni) |=> err_q != ERR_NONE);
  // R9
  err_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !err_clr_ni |=> err_q == ERR_NONE && !ovf_q);
  // R8
  ovf_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_q) |=> !word_rcv_no);
endmodule

// File: rtl/serial_rx_deframer.sv
module serial_rx_deframer
  import srx_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int GAP_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              err_clr_ni,
  input  logic              short_ctl_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              burst_i,
  input  logic              rx_clk_i,
  input  logic              rx_data_i,
  input  logic              rd_hi_ni,
  output logic [DATA_W-1:0] word_o,
  output logic              word_sync_o,
  output logic              word_wi_o,
  output logic              word_par_o,
  output logic              ctl_sync_o,
  output logic              ctl_data_o,
  output logic              ctl_cmd_o,
  output logic              ctl_bit4_o,
  output logic              word_rcv_no,
  output logic              ctl_rcv_no,
  output logic [1:0]        err_o,
  output logic              ovf_o
);
  logic              bit_stb, end_stb;
  logic              ctl_evt, word_evt, err_evt;
  err_code_e         evt_err;
  logic [DATA_W-1:0] w_data;
  logic              w_sync, w_wi, w_par, c_sync, c_data, c_cmd, c_bit4;

  srx_edge #(.GAP_CYC(GAP_CYC)) u_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rx_clk_i  (rx_clk_i),
    .bit_stb_o (bit_stb),
    .end_stb_o (end_stb)
  );

  srx_frame #(.DATA_W(DATA_W)) u_frame (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bit_stb_i   (bit_stb),
    .bit_val_i   (rx_data_i),
    .end_stb_i   (end_stb),
    .short_ctl_i (short_ctl_i),
    .par_en_i    (par_en_i),
    .par_odd_i   (par_odd_i),
    .burst_i     (burst_i),
    .ctl_evt_o   (ctl_evt),
    .word_evt_o  (word_evt),
    .err_evt_o   (err_evt),
    .evt_err_o   (evt_err),
    .w_data_o    (w_data),
    .w_sync_o    (w_sync),
    .w_wi_o      (w_wi),
    .w_par_o     (w_par),
    .c_sync_o    (c_sync),
    .c_data_o    (c_data),
    .c_cmd_o     (c_cmd),
    .c_bit4_o    (c_bit4)
  );

  srx_flags u_flags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .err_clr_ni  (err_clr_ni),
    .rd_hi_ni    (rd_hi_ni),
    .err_evt_i   (err_evt),
    .evt_err_i   (evt_err),
    .word_evt_i  (word_evt),
    .ctl_evt_i   (ctl_evt),
    .err_o       (err_o),
    .ovf_o       (ovf_o),
    .word_rcv_no (word_rcv_no),
    .ctl_rcv_no  (ctl_rcv_no)
  );

  // data latches are outside the reset domain on purpose
  always_ff @(posedge clk_i) begin
    if (word_evt) begin
      word_o      <= w_data;
      word_sync_o <= w_sync;
      word_wi_o   <= w_wi;
      word_par_o  <= w_par;
    end
    if (ctl_evt) begin
      ctl_sync_o <= c_sync;
      ctl_data_o <= c_data;
      ctl_cmd_o  <= c_cmd;
      ctl_bit4_o <= c_bit4;
    end
  end

  // R7
  word_sync_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(word_rcv_no) && !word_sync_o) |-> err_o == 2'b11);
  // R7
  ctl_sync_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ctl_rcv_no) && !ctl_sync_o) |-> err_o == 2'b11);
  // R1
  pulse_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_rcv_no || word_rcv_no);
endmodule

// File: tb/serial_rx_deframer_tb_top.sv
module serial_rx_deframer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic err_clr_n = 1'b1, short_ctl = 1'b1, par_en = 1'b0, par_odd = 1'b1, burst = 1'b0;
  logic rx_clk = 1'b0, rx_data = 1'b0, rd_hi_n = 1'b1;
  logic [31:0] word;
  logic word_sync, word_wi, word_par, ctl_sync, ctl_data, ctl_cmd, ctl_bit4;
  logic word_rcv_n, ctl_rcv_n, ovf;
  logic [1:0] err;

  always #10 clk = ~clk;

  serial_rx_deframer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .err_clr_ni(err_clr_n), .short_ctl_i(short_ctl),
    .par_en_i(par_en), .par_odd_i(par_odd), .burst_i(burst), .rx_clk_i(rx_clk),
    .rx_data_i(rx_data), .rd_hi_ni(rd_hi_n), .word_o(word), .word_sync_o(word_sync),
    .word_wi_o(word_wi), .word_par_o(word_par), .ctl_sync_o(ctl_sync),
    .ctl_data_o(ctl_data), .ctl_cmd_o(ctl_cmd), .ctl_bit4_o(ctl_bit4),
    .word_rcv_no(word_rcv_n), .ctl_rcv_no(ctl_rcv_n), .err_o(err), .ovf_o(ovf)
  );

  typedef struct {
    logic [31:0] data;
    logic sync, wi, par;
    logic [1:0] err;
    logic ovf;
    bit chk;
    string req;
  } word_item_t;

  typedef struct {
    logic sync, dat, cmd, b4;
    logic [1:0] err;
    logic ovf;
    bit chk;
    string req;
  } ctl_item_t;

  word_item_t wq[$];
  ctl_item_t  cq[$];
  int nchk = 0, nerr = 0;
  logic [1:0] exp_err = 2'b00;
  logic exp_ovf = 1'b0, exp_unread = 1'b0;
  bit done = 0;

  task automatic check(string req, logic [63:0] act, logic [63:0] expv);
    nchk++;
    if (act !== expv) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic int rank(logic [1:0] e);
    case (e)
      2'b11: return 3;
      2'b01: return 2;
      2'b10: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic logic par_of(logic [31:0] d, logic odd);
    return odd ? ~^d : ^d;
  endfunction

  task automatic merge(logic [1:0] e);
    if (rank(e) > rank(exp_err)) exp_err = e;
  endtask

  task automatic push_ctl(logic s, logic d, logic c, logic b, logic [1:0] ferr, bit chk, string req);
    ctl_item_t it;
    merge(ferr);
    it.sync = s; it.dat = d; it.cmd = c; it.b4 = b;
    it.err = exp_err; it.ovf = exp_ovf; it.chk = chk; it.req = req;
    cq.push_back(it);
  endtask

  task automatic push_word(logic [31:0] d, logic s, logic w, logic p, logic [1:0] ferr, bit chk, string req);
    word_item_t it;
    merge(ferr);
    if (exp_unread) exp_ovf = 1'b1;
    exp_unread = 1'b1;
    it.data = d; it.sync = s; it.wi = w; it.par = p;
    it.err = exp_err; it.ovf = exp_ovf; it.chk = chk; it.req = req;
    wq.push_back(it);
  endtask

  // MSB of the n-bit field goes first; edges four clocks apart
  task automatic send(logic [127:0] v, int n, int tail);
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk); rx_clk = 1'b0; rx_data = v[i];
      @(negedge clk);
      @(negedge clk); rx_clk = 1'b1;
      @(negedge clk);
    end
    @(negedge clk); rx_clk = 1'b0;
    repeat (tail) @(negedge clk);
  endtask

  task automatic clear_err();
    @(negedge clk); err_clr_n = 1'b0;
    @(negedge clk); err_clr_n = 1'b1;
    exp_err = 2'b00; exp_ovf = 1'b0;
  endtask

  task automatic read_word();
    @(negedge clk); rd_hi_n = 1'b0;
    @(negedge clk);
    @(negedge clk); rd_hi_n = 1'b1;
    @(negedge clk);
    exp_unread = 1'b0;
  endtask

  // scoreboard monitor
  logic wprev = 1'b1, cprev = 1'b1;
  always @(negedge clk) begin
    if (rst_n) begin
      if (wprev && !word_rcv_n) begin
        if (wq.size() == 0) begin
          nchk++; nerr++;
          $display("FAIL R2: actual=unexpected word pulse expected=none");
        end else begin
          word_item_t it;
          it = wq.pop_front();
          check({it.req, " err"}, 64'(err), 64'(it.err));
          check({it.req, " ovf"}, 64'(ovf), 64'(it.ovf));
          if (it.chk) begin
            check({it.req, " data"}, 64'(word), 64'(it.data));
            check({it.req, " sync/wi/par"}, 64'({word_sync, word_wi, word_par}),
                  64'({it.sync, it.wi, it.par}));
          end
        end
      end
      if (cprev && !ctl_rcv_n) begin
        if (cq.size() == 0) begin
          nchk++; nerr++;
          $display("FAIL R1: actual=unexpected frame pulse expected=none");
        end else begin
          ctl_item_t it;
          it = cq.pop_front();
          check({it.req, " err"}, 64'(err), 64'(it.err));
          check({it.req, " ovf"}, 64'(ovf), 64'(it.ovf));
          if (it.chk)
            check({it.req, " fields"}, 64'({ctl_sync, ctl_data, ctl_cmd, ctl_bit4}),
                  64'({it.sync, it.dat, it.cmd, it.b4}));
        end
      end
    end
    wprev = word_rcv_n;
    cprev = ctl_rcv_n;
  end

  // R4: pulse width measured at the port
  int wlow = 0;
  always @(negedge clk) begin
    if (!word_rcv_n) wlow++;
    else begin
      if (wlow != 0) check("R4 word pulse width", 64'(wlow), 64'd2);
      wlow = 0;
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] d1, d2, d3;
    logic p1, p2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // R10: reset state
    check("R10 reset err", 64'(err), 64'd0);
    check("R10 reset ovf", 64'(ovf), 64'd0);
    check("R10 reset pulses", 64'({word_rcv_n, ctl_rcv_n}), 64'b11);

    // R1: short frame
    short_ctl = 1'b1;
    push_ctl(1, 0, 1, 0, 2'b00, 1, "R1 short frame");
    send(128'b101, 3, 12);
    // R1: long frame
    short_ctl = 1'b0;
    push_ctl(1, 1, 0, 1, 2'b00, 1, "R1 long frame");
    send(128'b1101, 4, 12);

    // R2 R3: word without parity
    par_en = 1'b0;
    push_word(32'hA55A_0F3C, 1, 1, 0, 2'b00, 1, "R2 word no parity");
    send({94'd0, 1'b1, 1'b1, 32'hA55A_0F3C}, 34, 12);
    read_word();

    // R6: odd then even parity, both correct
    par_en = 1'b1; par_odd = 1'b1;
    d1 = 32'h1234_5678; p1 = par_of(d1, 1'b1);
    push_word(d1, 1, 0, p1, 2'b00, 1, "R6 odd parity ok");
    send({93'd0, 1'b1, 1'b0, d1, p1}, 35, 12);
    read_word();
    par_odd = 1'b0;
    d1 = 32'hFFFF_0001; p1 = par_of(d1, 1'b0);
    push_word(d1, 1, 1, p1, 2'b00, 1, "R6 even parity ok");
    send({93'd0, 1'b1, 1'b1, d1, p1}, 35, 12);
    read_word();
    // R6 R5: parity fault
    push_word(d1, 1, 1, ~p1, 2'b01, 1, "R6 parity fault");
    send({93'd0, 1'b1, 1'b1, d1, ~p1}, 35, 12);
    read_word();
    clear_err();
    // R9: clear visible at port
    check("R9 clear err", 64'(err), 64'd0);

    // R7: sync fault with bad parity reports sync
    d1 = 32'h0BAD_F00D; p1 = par_of(d1, 1'b0);
    push_word(d1, 0, 0, ~p1, 2'b11, 1, "R7 sync over parity");
    send({93'd0, 1'b0, 1'b0, d1, ~p1}, 35, 12);
    read_word();
    clear_err();

    // R5: short word gives bit-count code, then sticky behaviour (R7)
    par_en = 1'b0;
    push_word(32'h0, 1, 0, 0, 2'b10, 0, "R5 word length");
    send({98'd0, 30'h2AAA_AAAA}, 30, 12);
    read_word();
    push_word(32'h0000_00FF, 1, 0, 0, 2'b00, 1, "R7 sticky count code");
    send({94'd0, 1'b1, 1'b0, 32'h0000_00FF}, 34, 12);
    read_word();
    par_en = 1'b1; par_odd = 1'b1;
    d1 = 32'h8000_0000; p1 = par_of(d1, 1'b1);
    push_word(d1, 1, 0, ~p1, 2'b01, 1, "R7 parity outranks count");
    send({93'd0, 1'b1, 1'b0, d1, ~p1}, 35, 12);
    read_word();
    clear_err();
    check("R9 clear after faults", 64'({err, ovf}), 64'd0);

    // R8: overflow when unread
    par_en = 1'b0;
    push_word(32'h1111_1111, 1, 0, 0, 2'b00, 1, "R8 first word");
    send({94'd0, 1'b1, 1'b0, 32'h1111_1111}, 34, 12);
    push_word(32'h2222_2222, 1, 0, 0, 2'b00, 1, "R8 overwrite");
    send({94'd0, 1'b1, 1'b0, 32'h2222_2222}, 34, 12);
    read_word();
    clear_err();
    push_word(32'h3333_3333, 1, 0, 0, 2'b00, 1, "R8 read in time");
    send({94'd0, 1'b1, 1'b0, 32'h3333_3333}, 34, 12);
    read_word();

    // R3: pause of 6 idle clocks splits a 4-bit frame into two 2-bit frames
    short_ctl = 1'b0;
    push_ctl(1, 0, 0, 0, 2'b10, 0, "R3 split part one");
    push_ctl(1, 0, 0, 0, 2'b10, 0, "R3 split part two");
    send(128'b11, 2, 6);
    send(128'b10, 2, 12);
    check("R3 both parts seen", 64'(cq.size()), 64'd0);
    clear_err();

    // R11 R12: burst of two words with parity
    burst = 1'b1; par_en = 1'b1; par_odd = 1'b1;
    d1 = 32'hCAFE_0001; p1 = par_of(d1, 1'b1);
    d2 = 32'h0000_BEEF; p2 = par_of(d2, 1'b1);
    push_word(d1, 1, 1, p1, 2'b00, 1, "R11 burst word one");
    push_word(d2, 1, 1, p2, 2'b00, 1, "R12 burst word two header held");
    send({60'd0, 1'b1, 1'b1, d1, p1, d2, p2}, 68, 16);
    check("R11 burst words drained", 64'(wq.size()), 64'd0);
    read_word();
    clear_err();

    // R12: leftover bits after last word, no parity
    par_en = 1'b0;
    d3 = 32'h5A5A_C3C3;
    push_word(d3, 1, 0, 0, 2'b00, 1, "R12 burst word before tail");
    send({89'd0, 1'b1, 1'b0, d3, 5'b10110}, 39, 16);
    check("R12 tail count code", 64'(err), 64'b10);
    check("R12 tail no pulse", 64'(wq.size()), 64'd0);
    burst = 1'b0;

    // R10: reset keeps word latch, clears flags
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    exp_err = 2'b00; exp_ovf = 1'b0; exp_unread = 1'b0;
    repeat (2) @(negedge clk);
    check("R10 latch kept", 64'(word), 64'(d3));
    check("R10 flags cleared", 64'({err, ovf}), 64'd0);

    repeat (10) @(negedge clk);
    check("queues empty", 64'(wq.size() + cq.size()), 64'd0);
    finish_run();
  end
endmodule